// File: doc/BRIEF.md
# Complementary Switch Driver with Programmable Dead Times

This block turns a single PWM command into two drive signals for a pair of complementary power switches: a main drive that follows the command and an auxiliary drive that conducts while the command is low. Every transition of the command opens a dead-time gap in which neither switch conducts. The leading-edge gap and the trailing-edge gap are timed by two separate counters, and each is loaded from its own count input. Either gap can be ended at once by a zero-voltage-sense input, so the next switch turns on as soon as its voltage has collapsed and not after a fixed wait.

All asynchronous inputs (PWM, enable and the two sense inputs) pass through two-flop synchronizers, and the drive outputs are registered. The auxiliary drive has two polarity variants, selected by a static input: an active-high variant for an n-channel switch that forms a true complement of the main drive, and an active-low variant for a p-channel switch. When enable is low the block sleeps. The main drive is held low and the auxiliary drive is released, which an output-enable that goes low shows. The count inputs are meant to be set so that both gaps together stay well inside one PWM period.

Top module: `dual_deadtime_driver`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `main_drv`, `aux_oe` and `aux_drv` are all 0.
- R2: With the block enabled and in the low phase (auxiliary conducting), a rise of `pwm_in` makes the auxiliary switch stop conducting after the 4th rising clock edge. `main_drv` then rises exactly `rise_gap + 1` cycles later.
- R3: With the block enabled and in the high phase (main on), a fall of `pwm_in` makes `main_drv` fall after the 4th rising clock edge. The auxiliary switch then starts conducting exactly `fall_gap + 1` cycles later.
- R4: `rise_gap` and `fall_gap` are independent unsigned counts from 0 to 2^CNT_W-1. Each is sampled when its gap starts, and a count of 0 gives a one-cycle gap.
- R5: While `zv_main_in` is high, a pending main turn-on fires on the next cycle, whatever `rise_gap` holds. The main drive rises 5 edges after the `pwm_in` rise when the sense input has settled before it.
- R6: While `zv_aux_in` is high, a pending auxiliary turn-on fires on the next cycle, whatever `fall_gap` holds.
- R7: The auxiliary switch conducts when `aux_oe`=1 and `aux_drv` XOR `aux_invert` = 1. That is, `aux_drv` is high-active for `aux_invert`=0 and low-active for `aux_invert`=1. `aux_drv` is 0 whenever `aux_oe` is 0.
- R8: Within 3 rising edges of `enable_in` falling, `main_drv`=0, `aux_oe`=0 and `aux_drv`=0. They stay so while `enable_in` is low, whatever `pwm_in` does. After `enable_in` rises, `aux_oe` rises on the 4th edge, and a high `pwm_in` then starts a rising gap.
- R9: If `pwm_in` falls while the rising gap is still counting, the main turn-on is cancelled: `main_drv` never rises, and the auxiliary switch conducts `fall_gap + 1` cycles after the cancelled gap ends.
- R10: If `pwm_in` rises while the falling gap is still counting, the auxiliary turn-on is cancelled, and `main_drv` rises `rise_gap + 1` cycles after the cancelled gap ends.
- R11: `main_drv` and the conducting state of the auxiliary switch are never both active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | PWM command, asynchronous |
| enable_in | input | 1 | Low puts the block to sleep, asynchronous |
| zv_main_in | input | 1 | Zero-voltage sense that ends the rising gap |
| zv_aux_in | input | 1 | Zero-voltage sense that ends the falling gap |
| rise_gap | input | CNT_W | Dead time before main turn-on, in cycles minus one |
| fall_gap | input | CNT_W | Dead time before auxiliary turn-on, in cycles minus one |
| aux_invert | input | 1 | 1 selects the active-low auxiliary polarity |
| main_drv | output | 1 | Main switch drive, active high |
| aux_drv | output | 1 | Auxiliary switch drive, polarity per `aux_invert` |
| aux_oe | output | 1 | Auxiliary output enable, 0 means released |

## Verification
A phase sequencer stuck in a gap state shows at once as both switches off for longer than the programmed count. A timer that loads or decrements wrongly moves the second edge of a transition by whole cycles, so the bench measures both edges of every transition against arithmetic expectations over every pair of counts and both polarities. Missed cancellation or missed sense handling shows up within a few cycles as a main pulse that should never appear, or as a late turn-on. Sleep faults appear within three cycles as a driven main output or an asserted output enable.

// File: rtl/ddt_pkg.sv
package ddt_pkg;

    localparam int SYNC_STAGES = 2;

    typedef enum logic [2:0] {
        PH_SLEEP    = 3'd0,
        PH_LOW      = 3'd1,
        PH_GAP_RISE = 3'd2,
        PH_HIGH     = 3'd3,
        PH_GAP_FALL = 3'd4
    } phase_e;

    typedef struct packed {
        logic pwm;
        logic en;
        logic zv_main;
        logic zv_aux;
    } sense_t;

    typedef struct packed {
        logic main_on;
        logic aux_on;
        logic awake;
    } drive_req_t;

    localparam int SENSE_W = $bits(sense_t);

    function automatic logic aux_pin_level(input logic conducting, input logic invert,
                                           input logic oe);
        return oe & (conducting ^ invert);
    endfunction

endpackage

// File: rtl/ddt_sync.sv
module ddt_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    pipe[i] <= '0;
                end else if (i == 0) begin
                    pipe[i] <= d;
                end else begin
                    pipe[i] <= pipe[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/ddt_gap_timer.sv
module ddt_gap_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          run,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    // R4: a running count steps down by exactly one per cycle
    p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
        (run && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    // R4: a load takes the programmed value
    p_load_value_r4: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/ddt_phase_seq.sv
module ddt_phase_seq
    import ddt_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  sense_t        sn,
    input  logic [CW-1:0] rise_gap,
    input  logic [CW-1:0] fall_gap,
    output drive_req_t    req
);
    localparam int N_TMR = 2;
    localparam int T_RISE = 0;
    localparam int T_FALL = 1;

    phase_e        ph, ph_nxt;
    logic          t_load [N_TMR];
    logic          t_run  [N_TMR];
    logic          t_exp  [N_TMR];
    logic [CW-1:0] t_val  [N_TMR];

    assign t_val[T_RISE] = rise_gap;
    assign t_val[T_FALL] = fall_gap;

    generate
        for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
            ddt_gap_timer #(.CW(CW)) i_tmr (
                .clk      (clk),
                .rst      (rst),
                .load     (t_load[i]),
                .run      (t_run[i]),
                .load_val (t_val[i]),
                .expired  (t_exp[i])
            );
        end
    endgenerate

    always_comb begin
        ph_nxt         = ph;
        t_load[T_RISE] = 1'b0;
        t_load[T_FALL] = 1'b0;
        t_run[T_RISE]  = 1'b0;
        t_run[T_FALL]  = 1'b0;
        if (!sn.en) begin
            ph_nxt = PH_SLEEP;
        end else begin
            unique case (ph)
                PH_SLEEP: begin
                    if (sn.pwm) begin
                        ph_nxt         = PH_GAP_RISE;
                        t_load[T_RISE] = 1'b1;
                    end else begin
                        ph_nxt = PH_LOW;
                    end
                end
                PH_LOW: begin
                    if (sn.pwm) begin
                        ph_nxt         = PH_GAP_RISE;
                        t_load[T_RISE] = 1'b1;
                    end
                end
                PH_GAP_RISE: begin
                    t_run[T_RISE] = 1'b1;
                    if (!sn.pwm) begin
                        ph_nxt         = PH_GAP_FALL;
                        t_load[T_FALL] = 1'b1;
                    end else if (sn.zv_main || t_exp[T_RISE]) begin
                        ph_nxt = PH_HIGH;
                    end
                end
                PH_HIGH: begin
                    if (!sn.pwm) begin
                        ph_nxt         = PH_GAP_FALL;
                        t_load[T_FALL] = 1'b1;
                    end
                end
                PH_GAP_FALL: begin
                    t_run[T_FALL] = 1'b1;
                    if (sn.pwm) begin
                        ph_nxt         = PH_GAP_RISE;
                        t_load[T_RISE] = 1'b1;
                    end else if (sn.zv_aux || t_exp[T_FALL]) begin
                        ph_nxt = PH_LOW;
                    end
                end
                default: ph_nxt = PH_SLEEP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph <= PH_SLEEP;
        end else begin
            ph <= ph_nxt;
        end
    end

    assign req.main_on = (ph == PH_HIGH);
    assign req.aux_on  = (ph == PH_LOW);
    assign req.awake   = (ph != PH_SLEEP);

    // R2: the rising gap holds while its timer still runs and no sense fires
    p_rise_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_GAP_RISE && sn.en && sn.pwm && !sn.zv_main && !t_exp[T_RISE])
        |=> (ph == PH_GAP_RISE));

    // R3: the falling gap holds while its timer still runs and no sense fires
    p_fall_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_GAP_FALL && sn.en && !sn.pwm && !sn.zv_aux && !t_exp[T_FALL])
        |=> (ph == PH_GAP_FALL));

    // R5: main zero-voltage sense ends the rising gap on the next cycle
    p_zv_main_r5: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_GAP_RISE && sn.en && sn.pwm && sn.zv_main) |=> (ph == PH_HIGH));

    // R6: auxiliary zero-voltage sense ends the falling gap on the next cycle
    p_zv_aux_r6: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_GAP_FALL && sn.en && !sn.pwm && sn.zv_aux) |=> (ph == PH_LOW));

    // R9: a fall during the rising gap cancels the main turn-on
    p_cancel_rise_r9: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_GAP_RISE && sn.en && !sn.pwm) |=> (ph == PH_GAP_FALL));

    // R10: a rise during the falling gap cancels the auxiliary turn-on
    p_cancel_fall_r10: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_GAP_FALL && sn.en && sn.pwm) |=> (ph == PH_GAP_RISE));

    // R11: the main phase is only ever entered through a gap
    p_main_via_gap_r11: assert property (@(posedge clk) disable iff (rst)
        (ph != PH_HIGH && ph_nxt == PH_HIGH) |-> (ph == PH_GAP_RISE));
endmodule

// File: rtl/ddt_drive_out.sv
module ddt_drive_out
    import ddt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  drive_req_t req,
    input  logic       en_now,
    input  logic       aux_invert,
    output logic       main_drv,
    output logic       aux_drv,
    output logic       aux_oe
);
    logic main_q, aux_on_q, oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            main_q   <= 1'b0;
            aux_on_q <= 1'b0;
            oe_q     <= 1'b0;
        end else begin
            main_q   <= req.main_on & en_now;
            aux_on_q <= req.aux_on & en_now;
            oe_q     <= req.awake & en_now;
        end
    end

    assign main_drv = main_q;
    assign aux_oe   = oe_q;
    assign aux_drv  = aux_pin_level(aux_on_q, aux_invert, oe_q);

    // R1: reset clears every drive register
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!main_q && !oe_q && !aux_on_q));

    // R8: a sleeping enable forces main low and releases the auxiliary output
    p_sleep_force_r8: assert property (@(posedge clk) disable iff (rst)
        !en_now |=> (!main_q && !oe_q));

    // R7: a released auxiliary output is driven at 0
    p_released_low_r7: assert property (@(posedge clk) disable iff (rst)
        !oe_q |-> !aux_drv);
endmodule

// File: rtl/dual_deadtime_driver.sv
module dual_deadtime_driver
    import ddt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwm_in,
    input  logic             enable_in,
    input  logic             zv_main_in,
    input  logic             zv_aux_in,
    input  logic [CNT_W-1:0] rise_gap,
    input  logic [CNT_W-1:0] fall_gap,
    input  logic             aux_invert,
    output logic             main_drv,
    output logic             aux_drv,
    output logic             aux_oe
);
    sense_t     raw, sn;
    drive_req_t req;

    assign raw.pwm     = pwm_in;
    assign raw.en      = enable_in;
    assign raw.zv_main = zv_main_in;
    assign raw.zv_aux  = zv_aux_in;

    ddt_sync #(.W(SENSE_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (sn)
    );

    ddt_phase_seq #(.CW(CNT_W)) i_seq (
        .clk      (clk),
        .rst      (rst),
        .sn       (sn),
        .rise_gap (rise_gap),
        .fall_gap (fall_gap),
        .req      (req)
    );

    ddt_drive_out i_out (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .en_now     (sn.en),
        .aux_invert (aux_invert),
        .main_drv   (main_drv),
        .aux_drv    (aux_drv),
        .aux_oe     (aux_oe)
    );

    // R11: main drive and auxiliary conduction never overlap at the ports
    p_no_overlap_r11: assert property (@(posedge clk) disable iff (rst)
        !(main_drv && aux_oe && (aux_drv ^ aux_invert)));
endmodule

// File: tb/test_dual_deadtime_driver.sv
module test_dual_deadtime_driver;
    localparam int CW   = 3;
    localparam int NMAX = 1 << CW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pwm = 1'b0, en = 1'b1, zvm = 1'b0, zva = 1'b0, inv = 1'b0;
    logic [CW-1:0] rg = '0, fg = '0;
    logic          main_drv, aux_drv, aux_oe;
    logic          aux_cond;
    int            cyc = 0;
    int            n_chk = 0, n_bad = 0, overlap = 0;
    int            t_aux, t_main, t0;
    bit            seen;

    dual_deadtime_driver #(.CNT_W(CW)) i_dual_deadtime_driver (
        .clk(clk), .rst(rst), .pwm_in(pwm), .enable_in(en),
        .zv_main_in(zvm), .zv_aux_in(zva), .rise_gap(rg), .fall_gap(fg),
        .aux_invert(inv), .main_drv(main_drv), .aux_drv(aux_drv), .aux_oe(aux_oe)
    );

    assign aux_cond = aux_oe & (aux_drv ^ inv);

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (!rst && main_drv && aux_cond) overlap <= overlap + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // drive pwm to level v, then time the first change of aux conduction and main
    task automatic edge_run(input logic v);
        logic a0, m0;
        @(negedge clk);
        a0 = aux_cond; m0 = main_drv;
        t0 = cyc; pwm = v; t_aux = -1; t_main = -1;
        for (int k = 0; k < 40 && (t_aux < 0 || t_main < 0); k++) begin
            @(negedge clk);
            if (t_aux < 0 && aux_cond != a0) t_aux = cyc - t0;
            if (t_main < 0 && main_drv != m0) t_main = cyc - t0;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        idle(3);
        // R1: outputs quiet in reset
        check(main_drv == 0 && aux_oe == 0 && aux_drv == 0, "R1 reset outputs",
              {main_drv, aux_oe, aux_drv}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(main_drv == 0 && aux_oe == 0, "R1 after reset", {main_drv, aux_oe}, 0);
        idle(8);
        check(aux_oe == 1 && aux_cond == 1, "R8 wake to low phase", {aux_oe, aux_cond}, 3);

        // R2 R3 R4 R7: sweep all gap pairs and both polarities
        for (int p = 0; p < 2; p++) begin
            inv = p[0];
            idle(2);
            for (int a = 0; a < NMAX; a++) begin
                for (int b = 0; b < NMAX; b++) begin
                    rg = a[CW-1:0]; fg = b[CW-1:0];
                    check(aux_drv == ~inv, "R7 aux level while conducting", aux_drv, ~inv);
                    edge_run(1'b1);
                    check(t_aux == 4, "R2 aux off delay", t_aux, 4);
                    check(t_main == 5 + a, "R2 R4 main on delay", t_main, 5 + a);
                    check(aux_drv == inv, "R7 aux level while off", aux_drv, inv);
                    edge_run(1'b0);
                    check(t_main == 4, "R3 main off delay", t_main, 4);
                    check(t_aux == 5 + b, "R3 R4 aux on delay", t_aux, 5 + b);
                end
            end
        end
        inv = 1'b0;
        rg = 3'd7; fg = 3'd7;

        // R5: main sense cuts the rising gap
        zvm = 1'b1; idle(4);
        edge_run(1'b1);
        check(t_main == 5, "R5 main sense turn-on", t_main, 5);
        zvm = 1'b0;
        // R6: aux sense cuts the falling gap
        zva = 1'b1; idle(4);
        edge_run(1'b0);
        check(t_aux == 5, "R6 aux sense turn-on", t_aux, 5);
        zva = 1'b0; idle(4);

        // R9: fall during rising gap cancels main
        rg = 3'd7; fg = 3'd2;
        @(negedge clk); pwm = 1'b1; idle(2);
        t0 = cyc; pwm = 1'b0; seen = 0; t_aux = -1;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (main_drv) seen = 1;
            if (t_aux < 0 && cyc - t0 > 2 && aux_cond) t_aux = cyc - t0;
        end
        check(!seen, "R9 main never on", seen, 0);
        check(t_aux == 5 + 2, "R9 aux after cancel", t_aux, 7);

        // R10: rise during falling gap cancels aux
        rg = 3'd3; fg = 3'd7;
        edge_run(1'b1); idle(2);
        @(negedge clk); pwm = 1'b0; idle(2);
        t0 = cyc; pwm = 1'b1; seen = 0; t_main = -1;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (aux_cond) seen = 1;
            if (t_main < 0 && cyc - t0 > 2 && main_drv) t_main = cyc - t0;
        end
        check(!seen, "R10 aux never on", seen, 0);
        check(t_main == 5 + 3, "R10 main after cancel", t_main, 8);

        // R8: sleep from the high phase
        @(negedge clk); en = 1'b0; idle(3);
        check(main_drv == 0 && aux_oe == 0 && aux_drv == 0, "R8 sleep outputs",
              {main_drv, aux_oe, aux_drv}, 0);
        pwm = 1'b0; idle(6); pwm = 1'b1; idle(6);
        check(main_drv == 0 && aux_oe == 0, "R8 pwm ignored asleep", {main_drv, aux_oe}, 0);
        @(negedge clk); t0 = cyc; en = 1'b1; t_aux = -1; t_main = -1;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (t_aux < 0 && aux_oe) t_aux = cyc - t0;
            if (t_main < 0 && main_drv) t_main = cyc - t0;
        end
        check(t_aux == 4, "R8 wake enable delay", t_aux, 4);
        check(t_main == 5 + 3, "R8 wake into rising gap", t_main, 8);

        check(overlap == 0, "R11 no overlap", overlap, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule